// File: doc/BRIEF.md
# Flash Block Protection Gate and Status Register

This block sits between the command decoder of a flash device and its program/erase engine. For every program or erase request it judges, in one cycle, whether the target block may be touched. The judgement uses the block number, the level of the write-protect pin and a flag meaning the programming supply is below its lockout threshold. A permitted request produces a one-cycle start pulse to the engine. A refused request produces a one-cycle abort pulse instead: the engine never starts, the array is never touched, and an error bit is recorded.

The block also holds the 8-bit status register returned on status reads. It tracks whether the engine is busy, mirrors the engine's suspend state, and keeps four sticky error bits. The error bits survive later operations and are cleared only by an explicit clear-status pulse.

Only the lowest-numbered blocks (two by default) react to the write-protect pin. The supply lockout refuses every block.

Top module: `flash_guard_status`

## Requirements
- R1: After a synchronous active-low reset, `start_o` and `abort_o` are 0 and `status_o` reads 8'h80 (ready, no errors, no suspend).
- R2: When idle, a request to a block numbered 2 or above with the supply above lockout gives `start_o`=1 for exactly one cycle, in the cycle after the request. From that cycle on, status bit 7 reads 0 (busy) until the operation completes.
- R3: When idle, a request to block 0 or 1 with `wp_level_i` low gives `abort_o`=1 for one cycle and never gives `start_o`. In the same cycle as the abort, status bit 1 reads 1.
- R4: A request to block 0 or 1 with `wp_level_i` high and the supply above lockout is granted exactly as in R2.
- R5: When idle, a request with `vlock_i` high is aborted for any block and sets status bit 3 in the abort cycle. If the target is also held by the write-protect pin, bit 1 is set as well.
- R6: A completion pulse `done_i` while busy makes status bit 7 read 1 in the next cycle. If `fail_i` is high with it, bit 4 is set for a program operation, or bit 5 for an erase operation.
- R7: Error bits 1, 3, 4 and 5 stay set through later requests, grants and successful completions until a clear-status pulse.
- R8: A `clr_i` pulse clears bits 1, 3, 4 and 5 in the next cycle and leaves bits 7, 6 and 2 unaffected. An error raised in the same cycle as the clear wins, and its bit stays set.
- R9: A request made while busy is ignored: neither `start_o` nor `abort_o` pulses and the status does not change because of it.
- R10: Status bit 2 reads 1 when a program operation is busy and `psusp_i` was high in the previous cycle. Bit 6 does the same for an erase operation with `esusp_i`. Bit 0 always reads 0.
- R11: A `done_i` pulse while idle has no effect on the status, even with `fail_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Program or erase request, one-cycle pulse |
| req_erase_i | input | 1 | 1 = erase, 0 = program, valid with `req_i` |
| req_blk_i | input | BLK_W | Target block number |
| wp_level_i | input | 1 | Write-protect pin level, low protects the lockable blocks |
| vlock_i | input | 1 | Programming supply below lockout threshold |
| done_i | input | 1 | Engine completion pulse |
| fail_i | input | 1 | Completion reports a failure, valid with `done_i` |
| psusp_i | input | 1 | Engine reports program suspended |
| esusp_i | input | 1 | Engine reports erase suspended |
| clr_i | input | 1 | Clear-status command pulse |
| start_o | output | 1 | Permit: start the engine |
| abort_o | output | 1 | Request refused by protection |
| status_o | output | 8 | Status register value |

## Verification
On every cycle, the assertions check that start and abort are never raised together, and that no request is accepted while busy. They also check that a start always coincides with the busy state, that every abort is accompanied by a protection error bit, that error bits hold unless cleared, and that a clear takes effect when no error competes with it. The exact choice between bit 1 and bit 3, the failure bits set on completion, and the suspend mirroring can only be shown by the bench scenarios. So can the priority of a new error over a clear and the effect of completions while idle. The bench compares every output against a behavioural model on each clock.

// File: rtl/flash_guard_pkg.sv
// Package: shared bit positions and event type for the protection gate
// and status register. Bit positions are fixed because status reads
// are decoded by software at these positions.
package flash_guard_pkg;

    localparam int unsigned ST_W       = 8;
    localparam int unsigned ST_READY   = 7;
    localparam int unsigned ST_ESUSP   = 6;
    localparam int unsigned ST_EFAIL   = 5;
    localparam int unsigned ST_PFAIL   = 4;
    localparam int unsigned ST_VLOCK   = 3;
    localparam int unsigned ST_PSUSP   = 2;
    localparam int unsigned ST_LOCKERR = 1;

    localparam int unsigned ERR_N = 4;

    // Error-setting events produced by the operation tracker
    typedef struct packed {
        logic efail;   // erase completed with failure
        logic pfail;   // program completed with failure
        logic vlock;   // request refused by supply lockout
        logic lock;    // request refused by write-protect pin
    } err_evt_t;

endpackage

// File: rtl/fg_protect_eval.sv
// Module: fg_protect_eval
// Decides, combinationally, whether a block is protected. The lowest
// NUM_LOCK block numbers are lockable and protected while the
// write-protect level is low. A supply lockout protects every block.
// Assumes NUM_LOCK <= 2**BLK_W.
module fg_protect_eval #(
    parameter int unsigned BLK_W    = 6,
    parameter int unsigned NUM_LOCK = 2
) (
    input  logic [BLK_W-1:0] blk_i,
    input  logic             wp_level_i,
    input  logic             vlock_i,
    output logic             pin_lock_o,
    output logic             prot_o
);

    logic [NUM_LOCK-1:0] hit;

    // One comparator per lockable block number
    for (genvar gi = 0; gi < NUM_LOCK; gi++) begin : g_lockable
        assign hit[gi] = (blk_i == BLK_W'(gi));
    end

    // Combine pin-based and supply-based protection
    always_comb begin
        pin_lock_o = (|hit) && !wp_level_i;
        prot_o     = pin_lock_o || vlock_i;
    end

endmodule

// File: rtl/fg_op_tracker.sv
// Module: fg_op_tracker
// Accepts requests while idle, issues start or abort pulses, tracks the
// busy state and the type of the running operation, mirrors suspend
// flags, and emits error events. Assumes done_i arrives only for an
// operation it started; a done while idle is ignored.
module fg_op_tracker
    import flash_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_i,
    input  logic     req_erase_i,
    input  logic     prot_i,
    input  logic     pin_lock_i,
    input  logic     vlock_i,
    input  logic     done_i,
    input  logic     fail_i,
    input  logic     psusp_i,
    input  logic     esusp_i,
    output logic     start_o,
    output logic     abort_o,
    output logic     busy_o,
    output logic     psusp_o,
    output logic     esusp_o,
    output err_evt_t evt_o
);

    logic busy_q, erase_q, start_q, abort_q, psusp_q, esusp_q;
    logic accept, grant_d, deny_d, done_ev, busy_d, erase_d;

    // Next-state decisions for one request and one completion
    always_comb begin
        accept  = req_i && !busy_q;
        grant_d = accept && !prot_i;
        deny_d  = accept && prot_i;
        done_ev = done_i && busy_q;
        busy_d  = busy_q;
        if (done_ev)      busy_d = 1'b0;
        else if (grant_d) busy_d = 1'b1;
        erase_d = grant_d ? req_erase_i : erase_q;
        evt_o.lock  = deny_d && pin_lock_i;
        evt_o.vlock = deny_d && vlock_i;
        evt_o.pfail = done_ev && fail_i && !erase_q;
        evt_o.efail = done_ev && fail_i && erase_q;
    end

    // Operation state and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            erase_q <= 1'b0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
            psusp_q <= 1'b0;
            esusp_q <= 1'b0;
        end else begin
            busy_q  <= busy_d;
            erase_q <= erase_d;
            start_q <= grant_d;
            abort_q <= deny_d;
            psusp_q <= busy_d && !erase_d && psusp_i;
            esusp_q <= busy_d && erase_d && esusp_i;
        end
    end

    assign start_o = start_q;
    assign abort_o = abort_q;
    assign busy_o  = busy_q;
    assign psusp_o = psusp_q;
    assign esusp_o = esusp_q;

    // R3: permit and abort are mutually exclusive
    p_excl_start_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_q && abort_q));

    // R9: nothing is accepted while busy
    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !start_q && !abort_q);

    // R2: a start coincides with entry into busy
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_q);

    // R10: suspend flags only while busy
    p_susp_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (psusp_q || esusp_q) |-> busy_q);

endmodule

// File: rtl/fg_status_reg.sv
// Module: fg_status_reg
// Holds the sticky error bits. An event sets its bit; a clear pulse
// resets all error bits; a set in the same cycle as a clear wins.
// Assumes events are single-cycle pulses from the tracker.
module fg_status_reg
    import flash_guard_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  err_evt_t             evt_i,
    input  logic                 clr_i,
    output logic [ERR_N-1:0]     err_o
);

    logic [ERR_N-1:0] err_q;
    logic [ERR_N-1:0] set_v;

    assign set_v = evt_i;

    // Sticky bit update, set has priority over clear
    for (genvar gb = 0; gb < ERR_N; gb++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n)          err_q[gb] <= 1'b0;
            else if (set_v[gb])  err_q[gb] <= 1'b1;
            else if (clr_i)      err_q[gb] <= 1'b0;
        end

        // R7: an error bit holds unless a clear arrives
        p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[gb] && !clr_i) |=> err_q[gb]);

        // R8: a clear with no competing event empties the bit
        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_v[gb]) |=> !err_q[gb]);
    end

    assign err_o = err_q;

endmodule

// File: rtl/flash_guard_status.sv
// Module: flash_guard_status (top)
// Protection gate in front of the program/erase engine plus the device
// status register. Assumes the command decoder delivers single-cycle
// request, done and clear pulses.
module flash_guard_status
    import flash_guard_pkg::*;
#(
    parameter int unsigned BLK_W    = 6,
    parameter int unsigned NUM_LOCK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             req_erase_i,
    input  logic [BLK_W-1:0] req_blk_i,
    input  logic             wp_level_i,
    input  logic             vlock_i,
    input  logic             done_i,
    input  logic             fail_i,
    input  logic             psusp_i,
    input  logic             esusp_i,
    input  logic             clr_i,
    output logic             start_o,
    output logic             abort_o,
    output logic [7:0]       status_o
);

    logic             prot, pin_lock, busy, psusp, esusp;
    err_evt_t         evt;
    logic [ERR_N-1:0] err;
    err_evt_t         err_s;

    fg_protect_eval #(.BLK_W(BLK_W), .NUM_LOCK(NUM_LOCK)) u_prot (
        .blk_i      (req_blk_i),
        .wp_level_i (wp_level_i),
        .vlock_i    (vlock_i),
        .pin_lock_o (pin_lock),
        .prot_o     (prot)
    );

    fg_op_tracker u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .req_erase_i (req_erase_i),
        .prot_i      (prot),
        .pin_lock_i  (pin_lock),
        .vlock_i     (vlock_i),
        .done_i      (done_i),
        .fail_i      (fail_i),
        .psusp_i     (psusp_i),
        .esusp_i     (esusp_i),
        .start_o     (start_o),
        .abort_o     (abort_o),
        .busy_o      (busy),
        .psusp_o     (psusp),
        .esusp_o     (esusp),
        .evt_o       (evt)
    );

    fg_status_reg u_st (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt),
        .clr_i (clr_i),
        .err_o (err)
    );

    // Assemble the status word at its decoded bit positions
    always_comb begin
        err_s                = err;
        status_o             = '0;
        status_o[ST_READY]   = !busy;
        status_o[ST_ESUSP]   = esusp;
        status_o[ST_EFAIL]   = err_s.efail;
        status_o[ST_PFAIL]   = err_s.pfail;
        status_o[ST_VLOCK]   = err_s.vlock;
        status_o[ST_PSUSP]   = psusp;
        status_o[ST_LOCKERR] = err_s.lock;
    end

    // R3: an abort is always reported in the status in the same cycle
    p_abort_reports_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (status_o[ST_LOCKERR] || status_o[ST_VLOCK]));

    // R5: a request under supply lockout never starts the engine
    p_vlock_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && vlock_i) |=> !start_o);

    // R2: while a start pulses, the status shows busy
    p_start_busy_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !status_o[ST_READY]);

    // R10: bit 0 reads zero
    p_bit0_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[0]);

endmodule

// File: tb/flash_guard_status_tb_top.sv
`timescale 1ns/1ps
module flash_guard_status_tb_top;

    localparam int BW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 0, req_erase_i = 0, wp_level_i = 1, vlock_i = 0;
    logic [BW-1:0] req_blk_i = '0;
    logic          done_i = 0, fail_i = 0, psusp_i = 0, esusp_i = 0, clr_i = 0;
    logic          start_o, abort_o;
    logic [7:0]    status_o;

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R1";
    bit    started = 0;
    bit    finished = 0;

    always #4 clk = ~clk;

    flash_guard_status #(.BLK_W(BW), .NUM_LOCK(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_erase_i(req_erase_i),
        .req_blk_i(req_blk_i), .wp_level_i(wp_level_i), .vlock_i(vlock_i),
        .done_i(done_i), .fail_i(fail_i), .psusp_i(psusp_i), .esusp_i(esusp_i),
        .clr_i(clr_i), .start_o(start_o), .abort_o(abort_o), .status_o(status_o)
    );

    // Behavioural reference model of the requirements
    bit m_busy, m_erase, m_start, m_abort, m_ps, m_es;
    bit e_lock, e_vl, e_pf, e_ef;

    always @(posedge clk) begin
        bit acc, locked, protect, g, d, fin, nb, ne;
        started = 1;
        if (!rst_n) begin
            m_busy = 0; m_erase = 0; m_start = 0; m_abort = 0; m_ps = 0; m_es = 0;
            e_lock = 0; e_vl = 0; e_pf = 0; e_ef = 0;
        end else begin
            acc     = req_i && !m_busy;
            locked  = (int'(req_blk_i) < 2) && !wp_level_i;
            protect = locked || vlock_i;
            g   = acc && !protect;
            d   = acc && protect;
            fin = done_i && m_busy;
            nb  = fin ? 1'b0 : (g ? 1'b1 : m_busy);
            ne  = g ? req_erase_i : m_erase;
            if (d && locked)                e_lock = 1; else if (clr_i) e_lock = 0;
            if (d && vlock_i)               e_vl = 1;   else if (clr_i) e_vl = 0;
            if (fin && fail_i && !m_erase)  e_pf = 1;   else if (clr_i) e_pf = 0;
            if (fin && fail_i && m_erase)   e_ef = 1;   else if (clr_i) e_ef = 0;
            m_ps = nb && !ne && psusp_i;
            m_es = nb && ne && esusp_i;
            m_busy = nb; m_erase = ne; m_start = g; m_abort = d;
        end
    end

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        logic [7:0] exp_st;
        if (started && !finished) begin
            exp_st = {!m_busy, m_es, e_ef, e_pf, e_vl, m_ps, e_lock, 1'b0};
            checks++;
            if (start_o !== m_start) begin
                failures++;
                $display("FAIL %s start_o got %b exp %b at %0t", cur_tag, start_o, m_start, $time);
            end
            checks++;
            if (abort_o !== m_abort) begin
                failures++;
                $display("FAIL %s abort_o got %b exp %b at %0t", cur_tag, abort_o, m_abort, $time);
            end
            checks++;
            if (status_o !== exp_st) begin
                failures++;
                $display("FAIL %s status_o got %h exp %h at %0t", cur_tag, status_o, exp_st, $time);
            end
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic request(int blk, bit erase);
        req_i = 1; req_blk_i = BW'(blk); req_erase_i = erase;
        step();
        req_i = 0;
    endtask

    task automatic complete(bit fail);
        done_i = 1; fail_i = fail;
        step();
        done_i = 0; fail_i = 0;
    endtask

    task automatic clear_st();
        clr_i = 1;
        step();
        clr_i = 0;
    endtask

    // Explicit reset-state check, R1
    task automatic check_reset();
        checks++;
        if (status_o !== 8'h80 || start_o !== 0 || abort_o !== 0) begin
            failures++;
            $display("FAIL R1 reset state got %h/%b/%b exp 80/0/0", status_o, start_o, abort_o);
        end
    endtask

    initial begin
        @(negedge clk);
        step(3);
        rst_n = 1;
        step(2);
        cur_tag = "R1"; check_reset();

        cur_tag = "R2";  request(5, 0); step(2);
        cur_tag = "R10"; psusp_i = 1; step(3); psusp_i = 0; step(1);
        cur_tag = "R9";  wp_level_i = 0; request(0, 0); request(7, 1); step(1);
        cur_tag = "R6";  complete(0); step(2);

        cur_tag = "R3";  request(0, 0); step(1); request(1, 1); step(2);
        cur_tag = "R4";  wp_level_i = 1; request(1, 1); step(2);
        cur_tag = "R10"; esusp_i = 1; psusp_i = 1; step(3); esusp_i = 0; psusp_i = 0; step(1);
        cur_tag = "R6";  complete(1); step(2);
        cur_tag = "R7";  request(3, 0); step(2); complete(0); step(2);
        cur_tag = "R11"; complete(1); step(2);

        cur_tag = "R5";  vlock_i = 1; request(9, 0); step(1);
        wp_level_i = 0; request(0, 1); step(1); vlock_i = 0; wp_level_i = 1;
        cur_tag = "R8";  clear_st(); step(2);
        cur_tag = "R8";  wp_level_i = 0; clr_i = 1; request(1, 0); clr_i = 0; step(2);
        wp_level_i = 1;
        cur_tag = "R8";  request(4, 0); step(1); clear_st(); step(1); complete(1); step(2);
        cur_tag = "R7";  request(2, 1); step(1); complete(0); step(2);
        clear_st(); step(2);
        cur_tag = "R1";  rst_n = 0; step(2); rst_n = 1; step(1); check_reset();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired got running exp finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule